// File: doc/BRIEF.md
# Indirect Data Address Generator

This block turns one channel command's data-area description into the stream of real storage byte addresses that the channel uses for the transfer. It takes the command's 24-bit address field, its indirect flag, a read-backward indication and a byte count. The caller pulses `start` while the block is idle. When the indirect flag is clear, the address field is the first byte address, and the block steps it up by one per byte, or down by one per byte for read backward. When the flag is set, the address field points at a list of four-byte pointer words in storage. The block reads those words through a simple memory read port. Each word supplies the addresses for one 2 KiB storage block. When the current block is used up, the block reads the next word.

The indirect flag sits at bit 37 of the command doubleword, with bit 0 as the most significant bit. The caller extracts this bit and the 24-bit address field from bits 8 to 31 and presents them on `ccw_indirect` and `ccw_addr`. The flag has its usual meaning for read, read-backward, write, control and sense commands.

Byte addresses leave on a valid/ready stream. `out_valid` depends only on internal state. While `out_valid` is high and `out_ready` is low, `out_addr` holds steady. One address is accepted on each rising edge where both signals are high. The memory request port follows the same rule: `mem_req_addr` is held until `mem_req_ready` is seen. The read data returns with `mem_rsp_valid` on some later cycle. One cycle after the final byte address is accepted, `done` pulses for one cycle. A pointer word or list address that breaks the rules pulses `prog_chk` for one cycle and ends the transfer.

Top module: `indir_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `mem_req_valid`, `done`, `prog_chk` and `busy` are all low.
- R2: With the indirect flag clear and read-backward low, the addresses are `ccw_addr`, `ccw_addr+1`, and so on, exactly `byte_cnt` of them. No memory read is made. A 2 KiB boundary is crossed without any pause.
- R3: With the indirect flag clear and read-backward high, the addresses descend from `ccw_addr` by one per byte, across 2 KiB boundaries.
- R4: With the flag set, the first pointer word is read from `ccw_addr`. Its bits 23:0 (bits 8 to 31 in big-endian numbering) are the first byte address, and its low 11 bits may hold any value.
- R5: In a forward indirect transfer, after the byte whose address has its low 11 bits all ones, the next pointer word is read from the list address plus 4. The transfer then continues from the address in that word.
- R6: In a read-backward indirect transfer, addresses descend. After the byte whose low 11 bits are all zero, the next pointer word is read from the following list entry (list address plus 4).
- R7: A pointer word after the first must have data bits 10:0 all zero (forward) or all ones (read backward). Otherwise `prog_chk` pulses and no address from that word is issued.
- R8: A pointer word with any of data bits 31:24 (bits 0 to 7) nonzero causes a `prog_chk` pulse, and no address from it is issued.
- R9: With the flag set and `ccw_addr[1:0]` nonzero, `prog_chk` pulses and no memory read is made.
- R10: A pointer word is read only while bytes remain. A transfer that ends exactly at a 2 KiB edge makes no further read.
- R11: While `out_valid` is high and `out_ready` is low, `out_addr` stays unchanged. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_addr` stays unchanged.
- R12: `done` pulses for one cycle, one cycle after the last address is accepted. With `byte_cnt` of zero, `done` pulses with no address issued and no read made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| ccw_addr | input | 24 | Command address field: data area or list address |
| ccw_indirect | input | 1 | Indirect flag from the command |
| rd_back | input | 1 | Read-backward transfer |
| byte_cnt | input | 16 | Number of bytes to transfer |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Pointer-word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 24 | Word address of the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Pointer word read |
| out_valid | output | 1 | Byte address valid |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | 24 | Real byte address |
| done | output | 1 | One-cycle pulse: transfer complete |
| prog_chk | output | 1 | One-cycle pulse: invalid pointer word or list address |

## Verification
A wrong pointer-word read shows at the memory port as an extra request or a missing one. A stale list pointer shows as a request to the wrong entry, in the cycle right after the boundary byte is accepted. A wrong byte counter shows as a `done` pulse one beat early or late, or as an extra read past the end of the data. A bad validity decision shows within one cycle of the read response, either as a spurious `prog_chk` or as addresses taken from an illegal word. The bench stalls both handshakes so that stall-related state errors appear as changed addresses.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_XFER
  } walk_st_t;
endpackage

// File: rtl/idx_word_chk.sv
module idx_word_chk #(
  parameter int AW       = 24,
  parameter int WW       = 32,
  parameter int BLK_BITS = 11
) (
  input  logic [WW-1:0] word,
  input  logic          first,
  input  logic          rd_back,
  output logic          bad
);
  logic hi_bad, edge_bad;

  always_comb begin
    hi_bad   = |word[WW-1:AW];
    edge_bad = 1'b0;
    if (!first) begin
      if (rd_back) edge_bad = ~&word[BLK_BITS-1:0];
      else         edge_bad = |word[BLK_BITS-1:0];
    end
    bad = hi_bad | edge_bad;
  end
endmodule

// File: rtl/idx_addr_step.sv
module idx_addr_step #(
  parameter int AW       = 24,
  parameter int BLK_BITS = 11
) (
  input  logic [AW-1:0] cur,
  input  logic          rd_back,
  output logic [AW-1:0] nxt,
  output logic          at_edge
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    if (rd_back) begin
      nxt     = cur - ONE;
      at_edge = (cur[BLK_BITS-1:0] == '0);
    end else begin
      nxt     = cur + ONE;
      at_edge = &cur[BLK_BITS-1:0];
    end
  end
endmodule

// File: rtl/indir_addr_gen.sv
module indir_addr_gen
  import idx_pkg::*;
#(
  parameter int AW       = 24,
  parameter int WW       = 32,
  parameter int CW       = 16,
  parameter int BLK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ccw_addr,
  input  logic          ccw_indirect,
  input  logic          rd_back,
  input  logic [CW-1:0] byte_cnt,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [WW-1:0] mem_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          done,
  output logic          prog_chk
);
  localparam int              WORD_BYTES = WW / 8;
  localparam int              ALIGN_BITS = $clog2(WORD_BYTES);
  localparam logic [AW-1:0]   LIST_STEP  = AW'(WORD_BYTES);
  localparam logic [CW-1:0]   CNT_ONE    = CW'(1);

  walk_st_t      state;
  logic [AW-1:0] cur_q, lptr_q;
  logic [CW-1:0] remain_q;
  logic          first_q, ind_q, rb_q, done_q, pchk_q;

  logic [AW-1:0] step_nxt;
  logic          step_edge, word_bad;

  idx_addr_step #(.AW(AW), .BLK_BITS(BLK_BITS)) u_step (
    .cur     (cur_q),
    .rd_back (rb_q),
    .nxt     (step_nxt),
    .at_edge (step_edge)
  );

  idx_word_chk #(.AW(AW), .WW(WW), .BLK_BITS(BLK_BITS)) u_wchk (
    .word    (mem_rsp_data),
    .first   (first_q),
    .rd_back (rb_q),
    .bad     (word_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_q    <= '0;
      lptr_q   <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
      ind_q    <= 1'b0;
      rb_q     <= 1'b0;
      done_q   <= 1'b0;
      pchk_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pchk_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            ind_q    <= ccw_indirect;
            rb_q     <= rd_back;
            remain_q <= byte_cnt;
            first_q  <= 1'b1;
            if (byte_cnt == '0) begin
              done_q <= 1'b1;
            end else if (ccw_indirect) begin
              if (ccw_addr[ALIGN_BITS-1:0] != '0) begin
                pchk_q <= 1'b1;
              end else begin
                lptr_q <= ccw_addr;
                state  <= ST_REQ;
              end
            end else begin
              cur_q <= ccw_addr;
              state <= ST_XFER;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            lptr_q <= lptr_q + LIST_STEP;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (word_bad) begin
              pchk_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              cur_q   <= mem_rsp_data[AW-1:0];
              first_q <= 1'b0;
              state   <= ST_XFER;
            end
          end
        end
        ST_XFER: begin
          if (out_ready) begin
            remain_q <= remain_q - CNT_ONE;
            if (remain_q == CNT_ONE) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (ind_q && step_edge) begin
              state <= ST_REQ;
            end else begin
              cur_q <= step_nxt;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = lptr_q;
  assign out_valid     = (state == ST_XFER);
  assign out_addr      = cur_q;
  assign done          = done_q;
  assign prog_chk      = pchk_q;
endmodule

// File: rtl/indir_addr_gen_chk.sv
module indir_addr_gen_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          done,
  input logic          prog_chk
);
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !mem_req_valid && !busy));

  // R7
  pchk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_chk |-> (!out_valid && !busy));

  // R12
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, prog_chk, out_valid, mem_req_valid}));
endmodule

bind indir_addr_gen indir_addr_gen_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .done          (done),
  .prog_chk      (prog_chk)
);

// File: tb/tb_indir_addr_gen.sv
`timescale 1ns/1ps
module tb_indir_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ccw_addr = '0;
  logic        ccw_indirect = 1'b0;
  logic        rd_back = 1'b0;
  logic [15:0] byte_cnt = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [23:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_addr;
  logic        done;
  logic        prog_chk;

  always #4 clk = ~clk;

  indir_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ccw_addr(ccw_addr),
    .ccw_indirect(ccw_indirect), .rd_back(rd_back), .byte_cnt(byte_cnt),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .done(done), .prog_chk(prog_chk)
  );

  logic [31:0] mem [0:15];
  logic [23:0] req_log [0:7];
  int          fetches;
  int          checks = 0;
  int          fails = 0;
  logic [23:0] got [0:15];
  int          n_got;
  bit          saw_done, saw_pchk;
  int          bp_err;

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[5:2]];
    if (mem_req_valid && mem_req_ready) begin
      if (fetches < 8) req_log[fetches] <= mem_req_addr;
      fetches <= fetches + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] a, input logic ind, input logic rb,
                     input logic [15:0] cnt, input bit bp);
    bit          prev_stall = 1'b0;
    logic [23:0] prev_addr = '0;
    bit          rdy;
    @(negedge clk);
    fetches  = 0;
    n_got    = 0;
    saw_done = 1'b0;
    saw_pchk = 1'b0;
    bp_err   = 0;
    ccw_addr = a; ccw_indirect = ind; rd_back = rb; byte_cnt = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) saw_done = 1'b1;
      if (prog_chk) saw_pchk = 1'b1;
      if (saw_done || saw_pchk) break;
      if (prev_stall && (!out_valid || out_addr != prev_addr)) bp_err++;
      rdy = bp ? (k % 3 != 1) : 1'b1;
      out_ready = rdy;
      mem_req_ready = bp ? (k % 2 == 0) : 1'b1;
      if (out_valid && rdy && n_got < 16) begin
        got[n_got] = out_addr;
        n_got++;
      end
      prev_stall = out_valid && !rdy;
      prev_addr  = out_addr;
      @(negedge clk);
    end
    out_ready = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    chk(!done && !prog_chk && !busy, "R12 single-cycle end pulse", {30'd0, done, prog_chk}, 0);
  endtask

  task automatic expect_seq(input string req, input logic [23:0] base, input int n,
                            input bit down, input int split_at, input logic [23:0] base2);
    logic [23:0] e;
    chk(n_got == n, req, n_got, n);
    for (int i = 0; i < n && i < n_got; i++) begin
      if (i < split_at) e = down ? base - 24'(i) : base + 24'(i);
      else e = down ? base2 - 24'(i - split_at) : base2 + 24'(i - split_at);
      chk(got[i] == e, req, got[i], e);
    end
  endtask

  task automatic t_reset;
    chk(!out_valid && !mem_req_valid && !done && !prog_chk && !busy, "R1 reset outputs",
        {27'd0, out_valid, mem_req_valid, done, prog_chk, busy}, 0);
  endtask

  task automatic t_direct_fwd;
    run(24'h0007FD, 1'b0, 1'b0, 16'd5, 1'b0);
    expect_seq("R2 direct ascending", 24'h0007FD, 5, 1'b0, 99, 24'h0);
    chk(fetches == 0, "R2 no reads direct", fetches, 0);
    chk(saw_done && !saw_pchk, "R12 done after direct", {30'd0, saw_done, saw_pchk}, 2);
  endtask

  task automatic t_direct_back;
    run(24'h000802, 1'b0, 1'b1, 16'd4, 1'b1);
    expect_seq("R3 direct descending", 24'h000802, 4, 1'b1, 99, 24'h0);
    chk(fetches == 0, "R3 no reads", fetches, 0);
    chk(bp_err == 0, "R11 hold under stall", bp_err, 0);
  endtask

  task automatic t_ind_fwd;
    run(24'h000010, 1'b1, 1'b0, 16'd5, 1'b1);
    expect_seq("R4 R5 indirect forward", 24'h0107FE, 5, 1'b0, 2, 24'h002000);
    chk(fetches == 2, "R5 two reads", fetches, 2);
    chk(req_log[0] == 24'h10, "R4 first read at list", req_log[0], 24'h10);
    chk(req_log[1] == 24'h14, "R5 next entry +4", req_log[1], 24'h14);
    chk(bp_err == 0, "R11 hold under stall", bp_err, 0);
    chk(saw_done, "R12 done indirect", saw_done, 1);
  endtask

  task automatic t_exact_edge;
    run(24'h000018, 1'b1, 1'b0, 16'd2, 1'b0);
    expect_seq("R10 ends at edge", 24'h0007FE, 2, 1'b0, 99, 24'h0);
    chk(fetches == 1, "R10 no extra read", fetches, 1);
  endtask

  task automatic t_ind_back;
    run(24'h000020, 1'b1, 1'b1, 16'd4, 1'b0);
    expect_seq("R6 indirect backward", 24'h005001, 4, 1'b1, 2, 24'h000FFF);
    chk(fetches == 2, "R6 two reads", fetches, 2);
    chk(req_log[1] == 24'h24, "R6 next entry +4", req_log[1], 24'h24);
  endtask

  task automatic t_bad_edge;
    run(24'h000030, 1'b1, 1'b0, 16'd3, 1'b0);
    chk(saw_pchk && !saw_done, "R7 prog check on bad later word", {30'd0, saw_pchk, saw_done}, 2);
    chk(n_got == 1, "R7 no address from bad word", n_got, 1);
  endtask

  task automatic t_bad_high;
    run(24'h000038, 1'b1, 1'b0, 16'd3, 1'b0);
    chk(saw_pchk, "R8 prog check on high byte", saw_pchk, 1);
    chk(n_got == 0, "R8 no address issued", n_got, 0);
  endtask

  task automatic t_misaligned;
    run(24'h000012, 1'b1, 1'b0, 16'd3, 1'b0);
    chk(saw_pchk, "R9 prog check misaligned", saw_pchk, 1);
    chk(fetches == 0, "R9 no read", fetches, 0);
  endtask

  task automatic t_zero;
    run(24'h000010, 1'b1, 1'b0, 16'd0, 1'b0);
    chk(saw_done && n_got == 0, "R12 zero count done", n_got, 0);
    chk(fetches == 0, "R10 zero count no read", fetches, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    fetches = 0;
    mem[4]  = 32'h000107FE;
    mem[5]  = 32'h00002000;
    mem[6]  = 32'h000007FE;
    mem[8]  = 32'h00005001;
    mem[9]  = 32'h00000FFF;
    mem[12] = 32'h000007FF;
    mem[13] = 32'h00001004;
    mem[14] = 32'h01000100;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct_fwd();
    t_direct_back();
    t_ind_fwd();
    t_exact_edge();
    t_ind_back();
    t_bad_edge();
    t_bad_high();
    t_misaligned();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule